// File: doc/BRIEF.md
# GPIO Controller with Pin-Level Interrupts

A memory-mapped general purpose I/O block serving up to 32 pins. Software programs it over a 32-bit register bus: writes land on a clock edge and reads are combinational from the address. For each pin the block decides a single level. An external driver wins first. If there is none, the pin's own output wins when it is enabled. Otherwise the pull-up bit sets the level. The block then gates that level with a per-pin sense enable and stores the result in a read-only level register on every clock.

The stored level feeds four sticky pending sets: level-high, level-low, rising edge and falling edge. Each set has its own enable mask, and the enabled pending bits of a pin are ORed into that pin's interrupt line. Software clears a pending bit by writing a 1 to it. A pin that is driven from outside while its own output is enabled is flagged on a contention output. The drive-strength and both alternate-function registers are storage only.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, every register and every output reads as zero. On the first clock after reset, all low-pending bits set, because the sampled level is 0.
- R2: A pin's internal output is driveEn AND (outData XOR invert). padOutEn equals driveEn. padOut equals the resolved level where driveEn is 1 and is 0 elsewhere.
- R3: The resolved level is chosen in this order: the registered external value when padDriven was 1, then the internal output when driveEn is 1, then the pullUp bit.
- R4: The level register at offset 0x00 holds senseEn AND the resolved level. Bus writes to 0x00 are ignored.
- R5: A high-pending bit sets whenever the sampled level is 1, and a low-pending bit sets whenever it is 0. Both stay set until they are cleared, and they set again at once while the level persists.
- R6: A rise-pending bit sets when the new sample is 1 and the stored level is 0. A fall-pending bit sets for the opposite change.
- R7: A write to a pending register (riseP 0x1C, fallP 0x24, highP 0x2C, lowP 0x34) clears the bits where the data is 1 and keeps the other bits.
- R8: When a clear and a set condition fall on the same bit in the same cycle, the bit stays set.
- R9: pinIrq[i] is the OR over the four pending/enable pairs of pin i. The enables are riseE 0x18, fallE 0x20, highE 0x28 and lowE 0x30.
- R10: pinShort[i] is 1 exactly when padDriven[i] was 1 on the previous edge and driveEn[i] is 1.
- R11: Strength 0x14, altEn 0x38 and altSel 0x3C read back the written pin bits and have no effect on any pin or interrupt output.
- R12: Reads of unaligned or unmapped addresses return 0. Writes to those addresses change nothing. The remaining offsets are senseEn 0x04, driveEn 0x08, outData 0x0C, pullUp 0x10 and invert 0x40. Only the low NUM_PINS bits of each register are held.
- R13: padIn and padDriven are registered, so a pad change reaches the level register two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Byte address of the register |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, combinational from busAddr |
| padIn | input | NUM_PINS | External pin value |
| padDriven | input | NUM_PINS | 1 where an external device drives the pin |
| padOut | output | NUM_PINS | Level driven on the pad |
| padOutEn | output | NUM_PINS | Pad drive enable |
| pinIrq | output | NUM_PINS | Per-pin interrupt line |
| pinShort | output | NUM_PINS | Per-pin contention flag |

## Verification
A configuration write takes effect at the edge that accepts it. From that edge, padOut, padOutEn, pinShort, pinIrq and the register read-back are valid after the write. The level register and the pending bits move one edge later. A change on padIn or padDriven reaches pinShort after one edge and the level register after two. The bench waits exactly those edge counts before sampling, 1 ns after the edge or at the falling edge. One check confirms that the level has not yet moved after a single edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int NUM_REGS = 17;
  localparam int IDX_W    = 5;

  // Word index equals byte offset / 4.
  typedef enum logic [IDX_W-1:0] {
    IDX_LEVEL     = 5'd0,
    IDX_SENSE_EN  = 5'd1,
    IDX_DRIVE_EN  = 5'd2,
    IDX_OUT_DATA  = 5'd3,
    IDX_PULL_UP   = 5'd4,
    IDX_STRENGTH  = 5'd5,
    IDX_RISE_EN   = 5'd6,
    IDX_RISE_PEND = 5'd7,
    IDX_FALL_EN   = 5'd8,
    IDX_FALL_PEND = 5'd9,
    IDX_HIGH_EN   = 5'd10,
    IDX_HIGH_PEND = 5'd11,
    IDX_LOW_EN    = 5'd12,
    IDX_LOW_PEND  = 5'd13,
    IDX_ALT_EN    = 5'd14,
    IDX_ALT_SEL   = 5'd15,
    IDX_INVERT    = 5'd16,
    IDX_NONE      = 5'd31
  } regIdx_t;

  // Strobes from bus control to the pin datapath.
  typedef struct packed {
    logic [NUM_REGS-1:0] wr;
    regIdx_t             rdIdx;
  } busStrobe_t;

  function automatic logic isPending(int idx);
    return idx == int'(IDX_RISE_PEND) || idx == int'(IDX_FALL_PEND) ||
           idx == int'(IDX_HIGH_PEND) || idx == int'(IDX_LOW_PEND);
  endfunction

endpackage

// File: rtl/gpio_irq_ctrl_bus.sv
module gpio_irq_ctrl_bus
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              hit;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign hit     = (busAddr[1:0] == 2'b00) && (wordIdx < WORD_W'(NUM_REGS));

  always_comb begin
    strobe.rdIdx = hit ? regIdx_t'(wordIdx[IDX_W-1:0]) : IDX_NONE;
    for (int i = 0; i < NUM_REGS; i++) begin
      // The level register is read-only; its write strobe never fires.
      strobe.wr[i] = busWrEn && hit && (wordIdx == WORD_W'(i)) &&
                     (i != int'(IDX_LEVEL));
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl_pins.sv
module gpio_irq_ctrl_pins
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  busStrobe_t          strobe,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] padDriven,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic [NUM_PINS-1:0] pinIrq,
  output logic [NUM_PINS-1:0] pinShort
);

  logic [NUM_PINS-1:0] regView [NUM_REGS];
  logic [NUM_PINS-1:0] setVec  [NUM_REGS];
  logic [NUM_PINS-1:0] wrBits;
  logic [NUM_PINS-1:0] extLevel, extDriven;
  logic [NUM_PINS-1:0] driveEn, intOut, resolved, sample;

  assign wrBits = wrData[NUM_PINS-1:0];

  // Pad state captured as block state.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      extLevel  <= '0;
      extDriven <= '0;
    end else begin
      extLevel  <= padIn;
      extDriven <= padDriven;
    end
  end

  assign driveEn  = regView[IDX_DRIVE_EN];
  assign intOut   = driveEn & (regView[IDX_OUT_DATA] ^ regView[IDX_INVERT]);
  assign resolved = (extDriven & extLevel) |
                    (~extDriven & driveEn & intOut) |
                    (~extDriven & ~driveEn & regView[IDX_PULL_UP]);
  assign sample   = regView[IDX_SENSE_EN] & resolved;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) setVec[i] = '0;
    setVec[IDX_HIGH_PEND] = sample;
    setVec[IDX_LOW_PEND]  = ~sample;
    setVec[IDX_RISE_PEND] = sample & ~regView[IDX_LEVEL];
    setVec[IDX_FALL_PEND] = ~sample & regView[IDX_LEVEL];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [NUM_PINS-1:0] q;
    if (g == int'(IDX_LEVEL)) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= sample;
      end
    end else if (isPending(g)) begin : g_pend
      logic [NUM_PINS-1:0] clrMask;
      assign clrMask = strobe.wr[g] ? wrBits : '0;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clrMask) | setVec[g];
      end
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)            q <= '0;
        else if (strobe.wr[g]) q <= wrBits;
      end
    end
    assign regView[g] = q;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdIdx != IDX_NONE) rdData[NUM_PINS-1:0] = regView[strobe.rdIdx];
  end

  assign padOutEn = driveEn;
  assign padOut   = driveEn & resolved;
  assign pinShort = extDriven & driveEn;
  assign pinIrq   = (regView[IDX_HIGH_PEND] & regView[IDX_HIGH_EN]) |
                    (regView[IDX_LOW_PEND]  & regView[IDX_LOW_EN])  |
                    (regView[IDX_RISE_PEND] & regView[IDX_RISE_EN]) |
                    (regView[IDX_FALL_PEND] & regView[IDX_FALL_EN]);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] padDriven,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic [NUM_PINS-1:0] pinIrq,
  output logic [NUM_PINS-1:0] pinShort
);

  busStrobe_t strobe;

  gpio_irq_ctrl_bus #(.ADDR_W(ADDR_W)) u_bus (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_irq_ctrl_pins #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .padIn     (padIn),
    .padDriven (padDriven),
    .padOut    (padOut),
    .padOutEn  (padOutEn),
    .pinIrq    (pinIrq),
    .pinShort  (pinShort)
  );

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busWrEn,
  input logic [NUM_PINS-1:0] padDriven,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOutEn,
  input logic [NUM_PINS-1:0] pinIrq,
  input logic [NUM_PINS-1:0] pinShort
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pinIrq == '0 && padOutEn == '0 && pinShort == '0));

  assert_pad_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (padOut & ~padOutEn) == '0);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busWrEn) |-> ((pinIrq & $past(pinIrq)) == $past(pinIrq)));

  assert_short_needs_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pinShort & ~$past(padDriven)) == '0);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busWrEn   (busWrEn),
  .padDriven (padDriven),
  .padOut    (padOut),
  .padOutEn  (padOutEn),
  .pinIrq    (pinIrq),
  .pinShort  (pinShort)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

  localparam int NP = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_LEVEL = 8'h00, A_SENSE = 8'h04, A_DRIVE = 8'h08,
    A_OUTD = 8'h0C, A_PULL = 8'h10, A_STR = 8'h14, A_RISE_E = 8'h18,
    A_RISE_P = 8'h1C, A_FALL_E = 8'h20, A_FALL_P = 8'h24, A_HIGH_E = 8'h28,
    A_HIGH_P = 8'h2C, A_LOW_E = 8'h30, A_LOW_P = 8'h34, A_ALT_E = 8'h38,
    A_ALT_S = 8'h3C, A_INV = 8'h40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busWrEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic [NP-1:0] padIn = '0, padDriven = '0;
  logic [NP-1:0] padOut, padOutEn, pinIrq, pinShort;

  int total = 0;
  int failed = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padDriven(padDriven), .padOut(padOut), .padOutEn(padOutEn),
    .pinIrq(pinIrq), .pinShort(pinShort)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [DW-1:0] r;
    logic [NP-1:0] vDrv, vIn, vOe, vPort, vInv, vPue, vIe;
    logic [NP-1:0] eRes, eVal;

    // R1: reset state while reset is held
    repeat (3) @(posedge clk);
    for (int i = 0; i < 17; i++) begin
      rd(AW'(i * 4), r);
      check("R1 reg zero in reset", r, '0);
    end
    check("R1 irq", DW'(pinIrq), '0);
    check("R1 padOutEn", DW'(padOutEn), '0);
    @(negedge clk) rst_n = 1'b1;
    tick(1);
    rd(A_LOW_P, r);
    check("R1 low pending after first edge", r, 32'hF);

    // R2 R3 R4 R10: sweep of per-pin configurations
    for (int k = 0; k < 128; k++) begin
      for (int i = 0; i < NP; i++) begin
        automatic int c = (k + 37 * i) % 128;
        vDrv[i] = c[0]; vIn[i] = c[1]; vOe[i] = c[2]; vPort[i] = c[3];
        vInv[i] = c[4]; vPue[i] = c[5]; vIe[i] = c[6];
      end
      wr(A_SENSE, DW'(vIe));
      wr(A_DRIVE, DW'(vOe));
      wr(A_OUTD, DW'(vPort));
      wr(A_PULL, DW'(vPue));
      wr(A_INV, DW'(vInv));
      padIn = vIn; padDriven = vDrv;
      tick(2);
      for (int i = 0; i < NP; i++)
        eRes[i] = vDrv[i] ? vIn[i] : (vOe[i] ? (vPort[i] ^ vInv[i]) : vPue[i]);
      eVal = eRes & vIe;
      check("R2 padOut", DW'(padOut), DW'(eRes & vOe));
      check("R2 padOutEn", DW'(padOutEn), DW'(vOe));
      check("R10 pinShort", DW'(pinShort), DW'(vDrv & vOe));
      rd(A_LEVEL, r);
      check("R3 R4 level", r, DW'(eVal));
    end

    // Pending behaviour with external drive on all pins
    wr(A_SENSE, 32'hF); wr(A_DRIVE, 0); wr(A_PULL, 0); wr(A_INV, 0); wr(A_OUTD, 0);
    padDriven = 4'hF; padIn = 4'h0;
    tick(3);
    wr(A_RISE_P, 32'hF); wr(A_FALL_P, 32'hF); wr(A_HIGH_P, 32'hF);
    rd(A_RISE_P, r); check("R7 rise cleared", r, 0);
    rd(A_FALL_P, r); check("R7 fall cleared", r, 0);
    rd(A_HIGH_P, r); check("R7 high cleared", r, 0);
    wr(A_LOW_P, 32'hF);
    rd(A_LOW_P, r); check("R8 low set wins over clear", r, 32'hF);

    padIn = 4'b0101;
    tick(1);
    rd(A_LEVEL, r); check("R13 level not yet moved", r, 0);
    tick(1);
    rd(A_LEVEL, r); check("R13 level after two edges", r, 32'h5);
    rd(A_RISE_P, r); check("R6 rise", r, 32'h5);
    rd(A_HIGH_P, r); check("R5 high", r, 32'h5);
    rd(A_FALL_P, r); check("R6 no fall", r, 0);
    wr(A_RISE_P, 32'hF);
    rd(A_RISE_P, r); check("R7 rise cleared", r, 0);
    wr(A_HIGH_P, 32'hF);
    rd(A_HIGH_P, r); check("R5 high re-sets", r, 32'h5);

    padIn = 4'h0;
    tick(2);
    rd(A_FALL_P, r); check("R6 fall", r, 32'h5);
    rd(A_RISE_P, r); check("R6 no rise", r, 0);

    padIn = 4'hF;
    tick(2);
    rd(A_RISE_P, r); check("R6 rise all", r, 32'hF);
    wr(A_RISE_P, 32'h3);
    rd(A_RISE_P, r); check("R7 partial clear", r, 32'hC);

    // R9: interrupt combination (rise=1100 high=1111 fall=0101 low=1111)
    check("R9 no enables", DW'(pinIrq), 0);
    wr(A_RISE_E, 32'h1); check("R9 rise en masked", DW'(pinIrq), 0);
    wr(A_RISE_E, 32'h4); check("R9 rise", DW'(pinIrq), 32'h4);
    wr(A_HIGH_E, 32'h8); check("R9 high", DW'(pinIrq), 32'hC);
    wr(A_FALL_E, 32'h1); check("R9 fall", DW'(pinIrq), 32'hD);
    wr(A_LOW_E, 32'h2);  check("R9 low", DW'(pinIrq), 32'hF);
    wr(A_LOW_P, 32'hF);  check("R9 R7 low cleared drops irq", DW'(pinIrq), 32'hD);

    // R11: storage-only registers
    wr(A_STR, 32'hA); wr(A_ALT_E, 32'h5); wr(A_ALT_S, 32'hFFFF_FFFF);
    rd(A_STR, r);   check("R11 strength", r, 32'hA);
    rd(A_ALT_E, r); check("R11 altEn", r, 32'h5);
    rd(A_ALT_S, r); check("R11 altSel", r, 32'hF);
    check("R11 irq unchanged", DW'(pinIrq), 32'hD);
    check("R11 padOutEn unchanged", DW'(padOutEn), 0);
    rd(A_LEVEL, r); check("R11 level unchanged", r, 32'hF);

    // R12: unmapped and unaligned accesses
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, r); check("R12 unmapped read", r, 0);
    rd(8'h7C, r); check("R12 far unmapped read", r, 0);
    rd(8'h09, r); check("R12 unaligned read", r, 0);
    wr(8'h09, 32'hF);
    rd(A_DRIVE, r); check("R12 unaligned write ignored", r, 0);
    check("R12 padOutEn still 0", DW'(padOutEn), 0);
    rd(A_INV, r); check("R12 invert intact", r, 0);

    // R4: level register is read-only
    wr(A_LEVEL, 32'h0);
    tick(1);
    rd(A_LEVEL, r); check("R4 level write ignored", r, 32'hF);

    finishRun();
  end

endmodule